// File: doc/BRIEF.md
# Two-Wire Serial Register-File Slave

This block sits on a two-wire serial bus as a slave and gives the host access to a small bank of 8-bit configuration registers. It samples SCL and SDA with the system clock through two-flop synchronizers and finds Start and Stop conditions. It checks the first byte against a fixed 7-bit device address, and in a write transfer it takes a register pointer from the second byte. Data bytes then move one at a time, and the pointer advances after each byte. SDA is driven open-drain through an output enable that pulls the line low. The register contents are always visible as one flat parallel bus.

To read, a host writes the pointer byte, issues a repeated Start, and resends the address with the direction bit set. The edges of the register map have fixed rules. A pointer that names no register is refused. A write that runs past the top register is refused. A read that runs past the top register keeps returning the top register.

Top module: `i2c_reg_slave`

## Requirements
- R1: The first byte after a Start is {address[6:0], dir}, MSB first. It is acknowledged (SDA pulled low during the ninth SCL pulse) only when address equals DEV_ADDR. dir=0 selects a write, dir=1 selects a read. The slave never drives SDA while idle.
- R2: In a write transfer, each acknowledged data byte after the pointer byte is stored in the register named by the pointer, and the pointer then advances by one. regs_o[8*i+7:8*i] holds register i.
- R3: In a read transfer, the slave shifts out the register named by the pointer MSB first. After each master acknowledge the pointer advances by one.
- R4: A pointer byte whose value is NUM_REGS or higher is not acknowledged, no register changes, and the slave returns to idle.
- R5: A read that advances past register NUM_REGS-1 keeps returning the contents of register NUM_REGS-1 until the master gives a no-acknowledge.
- R6: A write data byte that arrives after register NUM_REGS-1 has been written is not stored, is not acknowledged, and the slave returns to idle.
- R7: A master no-acknowledge (SDA high during the ninth pulse) after a read byte ends the read, and the slave leaves SDA released.
- R8: A Stop at any point returns the slave to idle with SDA released. A Start at any point restarts the address phase. A byte cut off by either is discarded.
- R9: The slave changes SDA only while SCL is low, so SDA is stable through every SCL high period of a data or acknowledge bit.
- R10: After reset every register holds RST_VAL (default 0x00) and SDA is released.
- R11: A first byte with a non-matching address is not acknowledged, and the rest of that transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 8*NUM_REGS | Register contents, register i in bits 8*i+7:8*i |

## Verification
The hardest situations to reach are the map-edge cases and the interrupted byte. A write has to run past the top register, a read has to wrap past it with master acknowledges, and a Start or Stop has to land partway through a data byte. The bench drives a bit-level bus master. Random pointers reach past the top of the map, random burst lengths run from one to four bytes, and reads and writes are mixed at random. Directed transfers then abort a byte after a few bits with a Stop or a repeated Start and confirm that no register changed.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_RLOAD
  } slv_st_e;
endpackage

// File: rtl/i2c_sync_det.sv
module i2c_sync_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges qualify only when SCL is high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] RST_VAL  = 8'h00,
  localparam int        PW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [PW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [PW-1:0]         raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= RST_VAL;
      else if (we_i && waddr_i == PW'(g))       mem_q[g] <= wdata_i;
    end
    assign regs_o[g*8 +: 8] = mem_q[g];
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 8,
  localparam int        PW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [PW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [PW-1:0] raddr_o,
  output logic          idle_o,
  output logic          addr_o
);
  localparam logic [PW-1:0] TOP   = PW'(NUM_REGS - 1);
  localparam logic [8:0]    NREG9 = 9'(NUM_REGS);

  slv_st_e       st_q, nxt_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic          oe_q, ph_q, past_top_q;
  logic [PW-1:0] ptr_q;
  logic [7:0]    byte_in;
  logic          byte_end;

  function automatic logic [PW-1:0] sat_inc(logic [PW-1:0] p);
    return (p == TOP) ? p : p + 1'b1;
  endfunction

  assign byte_in  = {sh_q[6:0], sda_i};
  assign byte_end = scl_rise_i && cnt_q == 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      oe_q       <= 1'b0;
      ph_q       <= 1'b0;
      past_top_q <= 1'b0;
      ptr_q      <= '0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_q  <= byte_in;
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_end) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
            st_q  <= ST_IDLE;
            if (st_q == ST_ADDR) begin
              if (byte_in[7:1] == DEV_ADDR) begin
                st_q  <= ST_ACK;
                nxt_q <= byte_in[0] ? ST_RDATA : ST_PTR;
              end
            end else if (st_q == ST_PTR) begin
              if ({1'b0, byte_in} < NREG9) begin
                ptr_q      <= byte_in[PW-1:0];
                past_top_q <= 1'b0;
                st_q       <= ST_ACK;
                nxt_q      <= ST_WDATA;
              end
            end else if (!past_top_q) begin
              ptr_q      <= sat_inc(ptr_q);
              past_top_q <= (ptr_q == TOP);
              st_q       <= ST_ACK;
              nxt_q      <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (!ph_q) begin
              oe_q <= 1'b1;
              ph_q <= 1'b1;
            end else if (nxt_q == ST_RDATA) begin
              oe_q  <= ~rdata_i[7];
              sh_q  <= {rdata_i[6:0], 1'b0};
              cnt_q <= '0;
              st_q  <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= nxt_q;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) cnt_q <= cnt_q + 4'd1;
          if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              oe_q <= 1'b0;
              st_q <= ST_RACK;
            end else begin
              oe_q <= ~sh_q[7];
              sh_q <= {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            if (sda_i) st_q <= ST_IDLE;
            else begin
              ptr_q <= sat_inc(ptr_q);
              st_q  <= ST_RLOAD;
            end
          end
        end
        ST_RLOAD: begin
          if (scl_fall_i) begin
            oe_q  <= ~rdata_i[7];
            sh_q  <= {rdata_i[6:0], 1'b0};
            cnt_q <= '0;
            st_q  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o     = (st_q == ST_WDATA) && byte_end && !past_top_q && !start_i && !stop_i;
  assign waddr_o  = ptr_q;
  assign wdata_o  = byte_in;
  assign raddr_o  = ptr_q;
  assign sda_oe_o = oe_q;
  assign idle_o   = (st_q == ST_IDLE);
  assign addr_o   = (st_q == ST_ADDR);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] RST_VAL  = 8'h00,
  parameter int         STAGES   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int PW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          we, st_idle, st_addr;
  logic [PW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;

  i2c_sync_det #(.STAGES(STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) i_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rdata_i(rdata),
    .sda_oe_o, .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .raddr_o(raddr), .idle_o(st_idle), .addr_o(st_addr)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) i_bank (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata), .regs_o
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_oe_i,
  input logic [NUM_REGS*8-1:0] regs_i,
  input logic                  scl_i,
  input logic                  scl_rise_i,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  idle_i,
  input logic                  addr_i
);
  a_r9_oe_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_i);

  a_r8_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> idle_i && !sda_oe_i);

  a_r8_start_to_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> addr_i && !sda_oe_i);

  a_r2_regs_change_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> $past(scl_rise_i));

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_i);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .regs_i(regs_o),
  .scl_i(scl_s), .scl_rise_i(scl_rise), .start_i(start_det),
  .stop_i(stop_det), .idle_i(st_idle), .addr_i(st_addr)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NREG = 8;
  localparam int H = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o, sda_bus;
  logic [NREG*8-1:0] regs_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [4];

  always #2 clk_i = ~clk_i;
  assign sda_bus = sda_m & ~sda_oe_o;

  i2c_reg_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) i_i2c_reg_slave (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o, .regs_o
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_start();
    w(2); sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(2); sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      w(2); sda_m = b[i]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    w(2); sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2); ack = !sda_bus; w(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s1, s2;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      w(2); sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2); s1 = sda_bus;
      w(H/2 - 1); s2 = sda_bus;
      chk(s1 == s2, "R9 sda stable in scl high", int'(s2), int'(s1));
      b = {b[6:0], s1};
      w(1); scl_m = 1'b0;
    end
    w(2); sda_m = !mack; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[i*8 +: 8] == model[i], req, int'(regs_o[i*8 +: 8]), int'(model[i]));
  endtask

  task automatic wr_tx(input int ptr, input int n);
    bit ack, e;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk(ack, "R1 addr ack", int'(ack), 1);
    send_byte(8'(ptr), ack);
    e = ptr < NREG;
    chk(ack == e, "R4 ptr ack", int'(ack), int'(e));
    if (e) begin
      for (int k = 0; k < n; k++) begin
        send_byte(wbuf[k], ack);
        e = (ptr + k) < NREG;
        chk(ack == e, "R6 data ack", int'(ack), int'(e));
        if (!e) break;
        model[ptr + k] = wbuf[k];
      end
    end
    bus_stop();
    chk_regs(ptr >= NREG ? "R4 regs" : ((ptr + n) > NREG ? "R6 regs" : "R2 regs"));
  endtask

  task automatic rd_tx(input int ptr, input int n);
    bit ack;
    logic [7:0] b, e;
    int p;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'(ptr), ack);
    chk(ack, "R3 ptr ack", int'(ack), 1);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk(ack, "R1 read addr ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      p = (ptr + k < NREG) ? ptr + k : NREG - 1;
      e = model[p];
      chk(b == e, (ptr + k >= NREG) ? "R5 read top" : "R3 read", int'(b), int'(e));
    end
    w(4);
    chk(!sda_oe_o, "R7 released after nack", int'(sda_oe_o), 0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    int seed, ptr, n;
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    w(5); rst_ni = 1'b1; w(5);
    chk(!sda_oe_o, "R10 sda released", int'(sda_oe_o), 0);
    chk_regs("R10 reset regs");

    // wrong address
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R11 addr nack", int'(ack), 0);
    send_byte(8'h01, ack);
    chk(!ack, "R11 ptr ignored", int'(ack), 0);
    send_byte(8'h77, ack);
    chk(!ack, "R11 data ignored", int'(ack), 0);
    bus_stop();
    chk_regs("R11 regs");

    wbuf = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_tx(0, 4);
    wbuf = '{8'h15, 8'h26, 8'h37, 8'h48};
    wr_tx(6, 3);
    wr_tx(NREG, 1);
    rd_tx(0, 2);
    rd_tx(6, 4);

    // stop mid-byte
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_bits(8'hFF, 4);
    bus_stop();
    chk(!sda_oe_o, "R8 stop releases", int'(sda_oe_o), 0);
    chk_regs("R8 stop mid-byte");

    // repeated start mid-byte
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h03, ack);
    send_bits(8'h00, 3);
    bus_start();
    chk_regs("R8 start mid-byte");
    send_byte({ADDR, 1'b0}, ack);
    chk(ack, "R8 addr after restart", int'(ack), 1);
    send_byte(8'h03, ack);
    send_byte(8'h5A, ack);
    model[3] = 8'h5A;
    bus_stop();
    chk_regs("R8 write after restart");

    for (int it = 0; it < 30; it++) begin
      ptr = $urandom_range(NREG + 1, 0);
      n = $urandom_range(4, 1);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      if ($urandom_range(1, 0) == 1 && ptr < NREG) rd_tx(ptr, n);
      else wr_tx(ptr, n);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule